// File: doc/BRIEF.md
# Double-Precision Compare Flag Unit

This block is one pipeline stage that compares two IEEE-754 binary floating-point operands and turns the outcome into an update for a six-bit integer condition-flag register. Each operand is the low part of a wider source register. The default format is double precision. The exponent and fraction widths are parameters, so a reduced format can be built for test. Every valid input produces four things, all registered with one cycle of latency: a four-way outcome (unordered, greater, less, equal) encoded onto the zero, parity and carry flags; an invalid-operation status; a denormal-operand status; and a write-enable for the flag register.

A mode bit selects the exception rule. In quiet mode only a signaling NaN raises invalid. In signaling mode any NaN raises invalid. Two mask inputs decide which raised exceptions are masked. Any unmasked exception drops the flag write-enable. The exception status is still reported in that case, so the trap logic downstream can act on it.

Top module: `dpcmp_flag_stage`

## Requirements
- R1: `vld_o` equals `vld_i` delayed by one clock. When `vld_i` was low, `flag_we_o`, `inv_o` and `den_o` are low in the next cycle.
- R2: If either operand is a NaN, the result is unordered and `flags_o[2:0]` = 3'b111. A NaN has an all-ones exponent and a nonzero fraction.
- R3: Flag bit positions are: `flags_o[2]` zero, `flags_o[1]` parity, `flags_o[0]` carry. For ordered operands, A greater than B gives 3'b000, A less than B gives 3'b001, and equal gives 3'b100. +0 and -0 are equal. Infinities and subnormals order by their numeric value.
- R4: On every valid result, `flags_o[5:3]` (aux-carry at bit 3, sign at bit 4, overflow at bit 5) is 3'b000.
- R5: With `sig_mode_i`=0, `inv_o` is 1 only when at least one operand is a signaling NaN. A signaling NaN is a NaN whose top fraction bit is 0.
- R6: With `sig_mode_i`=1, `inv_o` is 1 whenever at least one operand is any NaN.
- R7: `den_o` is 1 when either operand is subnormal, meaning a zero exponent and a nonzero fraction.
- R8: A mask bit of 1 masks its exception. `flag_we_o` is 1 for a valid result unless `inv_o` is set with `inv_mask_i`=0, or `den_o` is set with `den_mask_i`=0.
- R9: Source bits above the floating-point width have no effect on any output.
- R10: While `rst` is high, every output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operands valid |
| src_a_i | input | SRC_W | First source register; only the low EXP_W+FRAC_W+1 bits are used |
| src_b_i | input | SRC_W | Second source register; only the low EXP_W+FRAC_W+1 bits are used |
| sig_mode_i | input | 1 | 0 = quiet compare, 1 = signaling compare |
| inv_mask_i | input | 1 | 1 masks the invalid-operation exception |
| den_mask_i | input | 1 | 1 masks the denormal-operand exception |
| vld_o | output | 1 | Result valid |
| flags_o | output | 6 | {OF, SF, AF, ZF, PF, CF} flag update |
| flag_we_o | output | 1 | Flag register write-enable |
| inv_o | output | 1 | Invalid-operation status for this result |
| den_o | output | 1 | Denormal-operand status for this result |

## Verification
The checker checks the following on every cycle:
- valid timing;
- the zeroed upper flags;
- the unordered code after any NaN;
- the two mode-dependent invalid rules;
- blocking of the write when invalid is unmasked.

The numeric ordering cannot be checked by those properties, because it needs a reference value for each operand. Neither can the exact denormal detection, or the combined effect of both masks. Only the bench's exhaustive sweep of a six-bit format shows these. That sweep covers every operand pair under every mode and mask setting, with the ignored upper source bits varying throughout.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_ZF = 2;
  localparam int FLG_AF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;
  localparam int FLG_W  = 6;

  // Zero/parity/carry code for a compare outcome
  function automatic logic [2:0] zpc_code(input cmp_res_e r);
    case (r)
      CMP_GT:  zpc_code = 3'b000;
      CMP_LT:  zpc_code = 3'b001;
      CMP_EQ:  zpc_code = 3'b100;
      default: zpc_code = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/dpcmp_classify.sv
module dpcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int FP_W  = EXP_W + FRAC_W + 1
) (
  input  logic [FP_W-1:0] val_i,
  output logic            sign_o,
  output logic            nan_o,
  output logic            snan_o,
  output logic            sub_o,
  output logic            zero_o,
  output logic [FP_W-2:0] mag_o
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    ex     = val_i[FP_W-2 -: EXP_W];
    fr     = val_i[FRAC_W-1:0];
    sign_o = val_i[FP_W-1];
    mag_o  = val_i[FP_W-2:0];
    nan_o  = (&ex) && (|fr);
    snan_o = nan_o && !fr[FRAC_W-1];
    sub_o  = (ex == '0) && (|fr);
    zero_o = (ex == '0) && (fr == '0);
  end
endmodule

// File: rtl/dpcmp_order.sv
module dpcmp_order
  import dpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             a_sign_i,
  input  logic             b_sign_i,
  input  logic             a_nan_i,
  input  logic             b_nan_i,
  input  logic             a_zero_i,
  input  logic             b_zero_i,
  input  logic [MAG_W-1:0] a_mag_i,
  input  logic [MAG_W-1:0] b_mag_i,
  output cmp_res_e         res_o
);
  logic mag_gt;

  always_comb begin
    mag_gt = a_mag_i > b_mag_i;
    if (a_nan_i || b_nan_i)
      res_o = CMP_UN;
    else if (a_zero_i && b_zero_i)
      res_o = CMP_EQ;
    else if (a_sign_i != b_sign_i)
      res_o = a_sign_i ? CMP_LT : CMP_GT;
    else if (a_mag_i == b_mag_i)
      res_o = CMP_EQ;
    else
      // both negative: larger magnitude is the smaller value
      res_o = (mag_gt ^ a_sign_i) ? CMP_GT : CMP_LT;
  end
endmodule

// File: rtl/dpcmp_flag_stage.sv
module dpcmp_flag_stage
  import dpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int SRC_W  = 128,
  localparam int FP_W  = EXP_W + FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [SRC_W-1:0] src_a_i,
  input  logic [SRC_W-1:0] src_b_i,
  input  logic             sig_mode_i,
  input  logic             inv_mask_i,
  input  logic             den_mask_i,
  output logic             vld_o,
  output logic [FLG_W-1:0] flags_o,
  output logic             flag_we_o,
  output logic             inv_o,
  output logic             den_o
);
  localparam int N_OPS = 2;

  logic [FP_W-1:0] opv   [N_OPS];
  logic            sgn   [N_OPS];
  logic            nan   [N_OPS];
  logic            snan  [N_OPS];
  logic            sub   [N_OPS];
  logic            zro   [N_OPS];
  logic [FP_W-2:0] mag   [N_OPS];

  assign opv[0] = src_a_i[FP_W-1:0];
  assign opv[1] = src_b_i[FP_W-1:0];

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    dpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i  (opv[g]),
      .sign_o (sgn[g]),
      .nan_o  (nan[g]),
      .snan_o (snan[g]),
      .sub_o  (sub[g]),
      .zero_o (zro[g]),
      .mag_o  (mag[g])
    );
  end

  cmp_res_e res;

  dpcmp_order #(.MAG_W(FP_W-1)) u_ord (
    .a_sign_i (sgn[0]),
    .b_sign_i (sgn[1]),
    .a_nan_i  (nan[0]),
    .b_nan_i  (nan[1]),
    .a_zero_i (zro[0]),
    .b_zero_i (zro[1]),
    .a_mag_i  (mag[0]),
    .b_mag_i  (mag[1]),
    .res_o    (res)
  );

  logic inv_raw, den_raw, blocked;

  always_comb begin
    inv_raw = sig_mode_i ? (nan[0] | nan[1]) : (snan[0] | snan[1]);
    den_raw = sub[0] | sub[1];
    blocked = (inv_raw & ~inv_mask_i) | (den_raw & ~den_mask_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      flags_o   <= '0;
      flag_we_o <= 1'b0;
      inv_o     <= 1'b0;
      den_o     <= 1'b0;
    end else begin
      vld_o     <= vld_i;
      flag_we_o <= vld_i & ~blocked;
      inv_o     <= vld_i & inv_raw;
      den_o     <= vld_i & den_raw;
      if (vld_i)
        flags_o <= {3'b000, zpc_code(res)};
    end
  end
endmodule

// File: rtl/dpcmp_flag_chk.sv
module dpcmp_flag_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int SRC_W  = 128,
  localparam int FP_W  = EXP_W + FRAC_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             vld_i,
  input logic [SRC_W-1:0] src_a_i,
  input logic [SRC_W-1:0] src_b_i,
  input logic             sig_mode_i,
  input logic             inv_mask_i,
  input logic             vld_o,
  input logic [5:0]       flags_o,
  input logic             flag_we_o,
  input logic             inv_o
);
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic any_nan, any_snan;

  always_comb begin
    ea = src_a_i[FP_W-2 -: EXP_W];
    eb = src_b_i[FP_W-2 -: EXP_W];
    fa = src_a_i[FRAC_W-1:0];
    fb = src_b_i[FRAC_W-1:0];
    any_nan  = ((&ea) && (fa != '0)) || ((&eb) && (fb != '0));
    any_snan = ((&ea) && (fa != '0) && !fa[FRAC_W-1]) ||
               ((&eb) && (fb != '0) && !fb[FRAC_W-1]);
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> (!vld_o && !flag_we_o && !inv_o)); // R1
  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    (vld_i && any_nan) |=> (flags_o[2:0] == 3'b111)); // R2
  AST_UPPER_FLAGS_ZERO: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (flags_o[5:3] == 3'b000)); // R4
  AST_QUIET_NO_INV: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !sig_mode_i && !any_snan) |=> !inv_o); // R5
  AST_SIG_NAN_INV: assert property (@(posedge clk) disable iff (rst)
    (vld_i && sig_mode_i && any_nan) |=> inv_o); // R6
  AST_INV_BLOCKS_WE: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !inv_mask_i) |=> !(inv_o && flag_we_o)); // R8
endmodule

bind dpcmp_flag_stage dpcmp_flag_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst(rst), .vld_i(vld_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
  .sig_mode_i(sig_mode_i), .inv_mask_i(inv_mask_i), .vld_o(vld_o),
  .flags_o(flags_o), .flag_we_o(flag_we_o), .inv_o(inv_o)
);

// File: tb/dpcmp_flag_stage_bench.sv
`timescale 1ns/1ps
module dpcmp_flag_stage_bench;
  localparam int EW = 3;
  localparam int FW = 2;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld_i = 1'b0;
  logic [SW-1:0] src_a_i = '0;
  logic [SW-1:0] src_b_i = '0;
  logic          sig_mode_i = 1'b0;
  logic          inv_mask_i = 1'b0;
  logic          den_mask_i = 1'b0;
  logic          vld_o, flag_we_o, inv_o, den_o;
  logic [5:0]    flags_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpcmp_flag_stage #(.EXP_W(EW), .FRAC_W(FW), .SRC_W(SW)) u_dpcmp_flag_stage (
    .clk(clk), .rst(rst), .vld_i(vld_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .sig_mode_i(sig_mode_i), .inv_mask_i(inv_mask_i), .den_mask_i(den_mask_i),
    .vld_o(vld_o), .flags_o(flags_o), .flag_we_o(flag_we_o),
    .inv_o(inv_o), .den_o(den_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // numeric value of a 6-bit float (sign, 3-bit exp, 2-bit fraction)
  function automatic int fval(input logic [5:0] x);
    int m;
    if (x[4:2] == 3'd0)      m = int'(x[1:0]);
    else if (x[4:2] == 3'd7) m = 1000;
    else                     m = (4 + int'(x[1:0])) << (int'(x[4:2]) - 1);
    return x[5] ? -m : m;
  endfunction

  function automatic bit is_nan(input logic [5:0] x);
    return (x[4:2] == 3'd7) && (x[1:0] != 2'd0);
  endfunction
  function automatic bit is_snan(input logic [5:0] x);
    return is_nan(x) && !x[1];
  endfunction
  function automatic bit is_sub(input logic [5:0] x);
    return (x[4:2] == 3'd0) && (x[1:0] != 2'd0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    vld_i = 1'b1;
    src_a_i = 8'h0F;
    @(negedge clk);
    // R10: reset holds outputs at zero even with valid input
    chk("R10 vld_o in reset", int'(vld_o), 0);
    chk("R10 flags_o in reset", int'(flags_o), 0);
    chk("R10 we/inv/den in reset", int'({flag_we_o, inv_o, den_o}), 0);
    vld_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'({vld_o, flag_we_o, inv_o, den_o}), 0);

    for (int md = 0; md < 2; md++) begin
      for (int mk = 0; mk < 4; mk++) begin
        for (int a = 0; a < 64; a++) begin
          for (int b = 0; b < 64; b++) begin
            logic [5:0] av, bv;
            bit nn, inv_e, den_e, we_e;
            int zpc, va, vb;
            av = 6'(a);
            bv = 6'(b);
            vld_i = 1'b1;
            sig_mode_i = md[0];
            inv_mask_i = mk[0];
            den_mask_i = mk[1];
            // R9: upper source bits vary and must not matter
            src_a_i = {2'(a + mk), av};
            src_b_i = {2'(b ^ md ^ a), bv};
            nn = is_nan(av) || is_nan(bv);
            va = fval(av);
            vb = fval(bv);
            if (nn)           zpc = 7;
            else if (va > vb) zpc = 0;
            else if (va < vb) zpc = 1;
            else              zpc = 4;
            inv_e = md[0] ? nn : (is_snan(av) || is_snan(bv));
            den_e = is_sub(av) || is_sub(bv);
            we_e  = !((inv_e && !mk[0]) || (den_e && !mk[1]));
            @(negedge clk);
            chk("R1 vld_o latency", int'(vld_o), 1);
            chk(nn ? "R2 unordered code" : "R3/R9 ordered code",
                int'(flags_o[2:0]), zpc);
            chk("R4 upper flags zero", int'(flags_o[5:3]), 0);
            chk(md[0] ? "R6 invalid signaling" : "R5 invalid quiet",
                int'(inv_o), int'(inv_e));
            chk("R7 denormal", int'(den_o), int'(den_e));
            chk("R8 write enable", int'(flag_we_o), int'(we_e));
          end
        end
      end
    end

    // R1: dropping valid clears status outputs next cycle
    vld_i = 1'b0;
    src_a_i = 8'h1F;
    @(negedge clk);
    chk("R1 idle vld_o", int'(vld_o), 0);
    chk("R1 idle we/inv/den", int'({flag_we_o, inv_o, den_o}), 0);
    finish_run();
  end
endmodule